// File: doc/BRIEF.md
# Serial-Fill Page Buffer

This block holds one page of data, 264 bytes, in a small SRAM-style array and fills it from a serial bit stream. Bit decode of the command byte happens upstream. The host then shifts in a 24-bit address header. The low 9 bits of that header give the byte slot where filling starts. Every later group of eight bits becomes one byte, stored at the current slot. After each byte the slot moves on by one and wraps from the last slot back to slot 0. Filling goes on until chip select is released.

Two header layouts exist. The plain fill form carries 15 unused bits ahead of the byte address. The fill-then-program form carries 6 reserved bits, a 9-bit page number, and then the byte address. In the second form the block also latches the page number, so that the program sequencer can use it later. The sequencer reaches the array through a separate parallel port. It uses this port to read the buffer for program and compare steps and to load it during page-to-buffer transfers.

Top module: `page_buf_writer`

## Requirements
- R1: After reset, `pageAddr` and `seqRData` are both zero and the serial side waits for an address header.
- R2: While `csN` is low, each `bitStb` pulse delivers one bit. The first 24 bits form the header, most significant bit first, and header bits 8..0 are the start byte slot. The data stream begins with the very next bit.
- R3: Data bits arrive most significant bit first. A byte is written to the current slot on its 8th bit, and the slot then increases by one.
- R4: After a byte is written to slot 263, the next byte goes to slot 0.
- R5: If the start slot is 264 or above, the first data byte is not stored anywhere and the second byte goes to slot 0.
- R6: A high level on `csN` ends the frame. A partial byte or a partial header is dropped, `bitStb` pulses while `csN` is high are ignored, and the next low period starts a new header.
- R7: If `cmdDirect` is high when the 24th header bit arrives, `pageAddr` takes header bits 17..9. Otherwise `pageAddr` keeps its value.
- R8: A parallel read (`seqEn`=1, `seqWe`=0) presents the data on `seqRData` one clock later. Slots 264 and above read as zero. A parallel write (`seqEn`=1, `seqWe`=1) stores `seqWData` at `seqAddr`.
- R9: If a serial byte is written in the same cycle as a parallel write, the serial byte is stored and the parallel write is dropped.
- R10: `seqRData` keeps its value in every cycle without a parallel read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low frame select |
| bitStb | input | 1 | One-cycle strobe that marks a valid serial bit |
| bitIn | input | 1 | Serial bit value |
| cmdDirect | input | 1 | High for the fill-then-program header layout |
| pageAddr | output | 9 | Latched page number |
| seqEn | input | 1 | Parallel access enable |
| seqWe | input | 1 | Parallel write when high, read when low |
| seqAddr | input | 9 | Parallel byte slot |
| seqWData | input | 8 | Parallel write data |
| seqRData | output | 8 | Parallel read data, one cycle after the request |

## Verification
The hardest case to reach is a parallel write that lands in exactly the cycle in which a serial byte is written. The bench handles this by driving the 8th data bit and the parallel write request on the same clock edge, once to the same slot and once to a different slot. Wraparound gets the next most care. It is reached by starting fills near the top of the buffer, by starting at slots that do not exist, and by running one fill longer than the whole buffer.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int PB_DEPTH = 264;
  localparam int PB_DW    = 8;
  localparam int PB_HDR   = 24;

  typedef enum logic {PH_HDR = 1'b0, PH_DATA = 1'b1} phase_t;

  typedef struct packed {
    logic shiftBit;
    logic commit;
  } pb_strobe_t;
endpackage

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
  import pbuf_pkg::*;
#(
  parameter int DEPTH = PB_DEPTH,
  parameter int DW    = PB_DW,
  parameter int HDR   = PB_HDR,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          bitStb,
  input  logic          bitIn,
  input  logic          cmdDirect,
  output pb_strobe_t    strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] pageAddr
);
  localparam int HCW = $clog2(HDR);
  localparam int DCW = $clog2(DW);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [HCW-1:0] HLAST = HCW'(HDR - 1);
  localparam logic [DCW-1:0] DLAST = DCW'(DW - 1);

  phase_t         phase;
  logic [HCW-1:0] hCnt;
  logic [DCW-1:0] dCnt;
  logic [HDR-1:0] hdrSr;
  logic [HDR-1:0] hdrNext;
  logic [AW-1:0]  ptr;
  logic           liveBit;

  assign liveBit = !csN && bitStb;
  assign hdrNext = {hdrSr[HDR-2:0], bitIn};

  always_comb begin
    strb.shiftBit = liveBit && (phase == PH_DATA);
    strb.commit   = strb.shiftBit && (dCnt == DLAST);
    wrAddr        = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_HDR;
      hCnt     <= '0;
      dCnt     <= '0;
      hdrSr    <= '0;
      ptr      <= '0;
      pageAddr <= '0;
    end else if (csN) begin
      phase <= PH_HDR;
      hCnt  <= '0;
      dCnt  <= '0;
    end else if (bitStb) begin
      if (phase == PH_HDR) begin
        hdrSr <= hdrNext;
        if (hCnt == HLAST) begin
          phase <= PH_DATA;
          dCnt  <= '0;
          ptr   <= hdrNext[AW-1:0];
          if (cmdDirect) pageAddr <= hdrNext[2*AW-1:AW];
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end else begin
        dCnt <= dCnt + 1'b1;
        if (dCnt == DLAST) ptr <= (ptr >= LAST) ? '0 : ptr + 1'b1;
      end
    end
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && wrAddr < LAST) |=> (ptr == $past(wrAddr) + 1'b1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && wrAddr == LAST) |=> (ptr == '0));
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (ptr <= LAST));
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (phase == PH_HDR && hCnt == '0 && !strb.shiftBit));
  a_r7_page_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(liveBit && phase == PH_HDR && cmdDirect) |=> $stable(pageAddr));
endmodule

// File: rtl/pbuf_data.sv
module pbuf_data
  import pbuf_pkg::*;
#(
  parameter int DEPTH = PB_DEPTH,
  parameter int DW    = PB_DW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitIn,
  input  pb_strobe_t    strb,
  input  logic [AW-1:0] wrAddr,
  input  logic          seqEn,
  input  logic          seqWe,
  input  logic [AW-1:0] seqAddr,
  input  logic [DW-1:0] seqWData,
  output logic [DW-1:0] seqRData
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] byteSr;
  logic [DW-1:0] byteNext;
  logic          serOk;
  logic          parOk;
  logic          rdReq;

  assign byteNext = {byteSr[DW-2:0], bitIn};
  assign serOk    = ({1'b0, wrAddr} < LIMIT);
  assign parOk    = ({1'b0, seqAddr} < LIMIT);
  assign rdReq    = seqEn && !seqWe;

  always_ff @(posedge clk) begin
    if (!rstN) byteSr <= '0;
    else if (strb.shiftBit) byteSr <= byteNext;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      if (serOk) mem[wrAddr] <= byteNext;
    end else if (seqEn && seqWe && parOk) begin
      mem[seqAddr] <= seqWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqRData <= '0;
    else if (rdReq) seqRData <= parOk ? mem[seqAddr] : '0;
  end

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(seqRData));
  a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !parOk) |=> (seqRData == '0));
endmodule

// File: rtl/page_buf_writer.sv
module page_buf_writer
  import pbuf_pkg::*;
#(
  parameter int DEPTH = PB_DEPTH,
  parameter int DW    = PB_DW,
  parameter int HDR   = PB_HDR,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          bitStb,
  input  logic          bitIn,
  input  logic          cmdDirect,
  output logic [AW-1:0] pageAddr,
  input  logic          seqEn,
  input  logic          seqWe,
  input  logic [AW-1:0] seqAddr,
  input  logic [DW-1:0] seqWData,
  output logic [DW-1:0] seqRData
);
  pb_strobe_t    strb;
  logic [AW-1:0] wrAddr;

  pbuf_ctrl #(.DEPTH(DEPTH), .DW(DW), .HDR(HDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .bitStb(bitStb), .bitIn(bitIn),
    .cmdDirect(cmdDirect), .strb(strb), .wrAddr(wrAddr), .pageAddr(pageAddr)
  );

  pbuf_data #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .strb(strb), .wrAddr(wrAddr),
    .seqEn(seqEn), .seqWe(seqWe), .seqAddr(seqAddr), .seqWData(seqWData),
    .seqRData(seqRData)
  );
endmodule

// File: tb/sim_page_buf_writer.sv
module sim_page_buf_writer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       bitStb = 1'b0;
  logic       bitIn = 1'b0;
  logic       cmdDirect = 1'b0;
  logic [8:0] pageAddr;
  logic       seqEn = 1'b0;
  logic       seqWe = 1'b0;
  logic [8:0] seqAddr = '0;
  logic [7:0] seqWData = '0;
  logic [7:0] seqRData;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [7:0] model [264];
  int expQ[$];
  int adrQ[$];
  string tagQ[$];
  logic rdFlag = 1'b0;

  always #5 clk = ~clk;

  page_buf_writer u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .bitStb(bitStb), .bitIn(bitIn),
    .cmdDirect(cmdDirect), .pageAddr(pageAddr), .seqEn(seqEn), .seqWe(seqWe),
    .seqAddr(seqAddr), .seqWData(seqWData), .seqRData(seqRData)
  );

  task automatic check(input string tag, input int got, input int exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(posedge clk) rdFlag <= seqEn && !seqWe;

  always @(negedge clk) begin
    if (rdFlag) begin
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R8: unexpected read result got 0x%0h expected none", seqRData);
      end else begin
        int e;
        int a;
        string t;
        e = expQ.pop_front();
        a = adrQ.pop_front();
        t = tagQ.pop_front();
        check($sformatf("%s slot %0d", t, a), int'(seqRData), e);
      end
    end
  end

  task automatic readExp(input int addr, input string tag);
    @(negedge clk);
    seqEn = 1'b1; seqWe = 1'b0; seqAddr = 9'(addr);
    expQ.push_back(addr < 264 ? int'(model[addr]) : 0);
    adrQ.push_back(addr);
    tagQ.push_back(tag);
    @(negedge clk);
    seqEn = 1'b0;
  endtask

  task automatic parWrite(input int addr, input int data);
    @(negedge clk);
    seqEn = 1'b1; seqWe = 1'b1; seqAddr = 9'(addr); seqWData = 8'(data);
    if (addr < 264) model[addr] = 8'(data);
    @(negedge clk);
    seqEn = 1'b0; seqWe = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitStb = 1'b1; bitIn = b;
    @(negedge clk);
    bitStb = 1'b0;
  endtask

  task automatic sendBits(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(val[i]);
  endtask

  task automatic sendHeader(input bit direct, input int pa, input int bfa);
    @(negedge clk);
    csN = 1'b0; cmdDirect = direct;
    if (direct) sendBits({6'b0, 9'(pa), 9'(bfa)}, 24);
    else sendBits({15'h5A5A, 9'(bfa)}, 24);
  endtask

  task automatic endFrame();
    @(negedge clk);
    csN = 1'b1; cmdDirect = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(input bit direct, input int pa, input int bfa,
                      input int nBytes, input int seed, input int extra);
    int ptr;
    ptr = bfa;
    sendHeader(direct, pa, bfa);
    for (int k = 0; k < nBytes; k++) begin
      int b;
      b = (seed + k * 13) & 8'hFF;
      sendBits(b, 8);
      if (ptr < 264) model[ptr] = 8'(b);
      ptr = (ptr >= 263) ? 0 : ptr + 1;
    end
    if (extra > 0) sendBits(8'hA5, extra);
    endFrame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", int'(seqRData), 0);
    check("R1 pageAddr after reset", int'(pageAddr), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", int'(seqRData), 0);

    for (int i = 0; i < 264; i++) parWrite(i, (i * 7 + 3) & 8'hFF);
    readExp(0, "R8 preload");
    readExp(137, "R8 preload");
    readExp(263, "R8 preload");
    readExp(300, "R8 out of range");
    readExp(511, "R8 out of range");

    fill(1'b0, 0, 5, 4, 8'h31, 0);
    for (int a = 4; a <= 9; a++) readExp(a, "R2 R3 fill at 5");

    readExp(6, "R10 setup");
    repeat (4) @(negedge clk);
    check("R10 hold idle", int'(seqRData), int'(model[6]));
    parWrite(70, 8'hEE);
    check("R10 hold after write", int'(seqRData), int'(model[6]));

    fill(1'b0, 0, 261, 6, 8'h90, 0);
    for (int a = 259; a <= 263; a++) readExp(a, "R4 wrap");
    for (int a = 0; a <= 3; a++) readExp(a, "R4 wrap");

    fill(1'b0, 0, 300, 3, 8'h44, 0);
    readExp(263, "R5 start out of range");
    readExp(0, "R5 start out of range");
    readExp(1, "R5 start out of range");
    readExp(2, "R5 start out of range");

    fill(1'b0, 0, 10, 2, 8'h17, 5);
    for (int a = 10; a <= 12; a++) readExp(a, "R6 partial byte");

    @(negedge clk); csN = 1'b0;
    sendBits(10'h2AB, 10);
    endFrame();
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    fill(1'b0, 0, 100, 2, 8'h5C, 0);
    for (int a = 99; a <= 102; a++) readExp(a, "R6 after aborted header");

    fill(1'b1, 9'h1A5, 20, 2, 8'h61, 0);
    check("R7 page latched", int'(pageAddr), 9'h1A5);
    readExp(20, "R7 data after page");
    readExp(21, "R7 data after page");
    fill(1'b0, 0, 30, 1, 8'h02, 0);
    check("R7 page kept on plain fill", int'(pageAddr), 9'h1A5);
    fill(1'b1, 9'h003, 263, 2, 8'h7E, 0);
    check("R7 second page", int'(pageAddr), 9'h003);
    readExp(263, "R7 R4 direct wrap");
    readExp(0, "R7 R4 direct wrap");

    sendHeader(1'b0, 0, 40);
    sendBits(8'hC3 >> 1, 7);
    @(negedge clk);
    bitStb = 1'b1; bitIn = 1'b1;
    seqEn = 1'b1; seqWe = 1'b1; seqAddr = 9'd40; seqWData = 8'h11;
    model[40] = 8'hC3;
    @(negedge clk);
    bitStb = 1'b0; seqEn = 1'b0; seqWe = 1'b0;
    sendBits(8'h3C >> 1, 7);
    @(negedge clk);
    bitStb = 1'b1; bitIn = 1'b0;
    seqEn = 1'b1; seqWe = 1'b1; seqAddr = 9'd50; seqWData = 8'h22;
    model[41] = 8'h3C;
    @(negedge clk);
    bitStb = 1'b0; seqEn = 1'b0; seqWe = 1'b0;
    endFrame();
    readExp(40, "R9 same slot collision");
    readExp(41, "R9 serial byte kept");
    readExp(50, "R9 parallel write dropped");

    fill(1'b0, 0, 0, 270, 8'h08, 0);
    for (int a = 0; a < 264; a += 29) readExp(a, "R4 long fill");
    readExp(5, "R4 long fill overwrite");
    readExp(6, "R4 long fill");
    readExp(263, "R4 long fill");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      nBad++;
      $display("FAIL R8: got %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule